// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Guard with Scrub

This block guards 64-bit memory words with a 72-bit code. On the write side it turns a data word into a stored codeword: seven Hamming check bits plus one overall parity bit. On the read side it takes a stored codeword with its address and returns the data one clock later. A single flipped bit anywhere in the 72 bits is repaired. Two flipped bits are reported as unrepairable.

When a read needed a repair and scrubbing is switched on, the block issues a write-back request. The request carries the address of the read and a freshly encoded, clean codeword, so that the memory controller can overwrite the damaged location. Two saturating event counters, one for repaired reads and one for unrepairable reads, let software spot a failing memory. An explicit clear input resets both counters.

Top module: `secded_scrub_unit`

## Requirements
- R1: `wr_code_o` is a combinational function of `wr_data_i`. Codeword bit 0 is the overall parity bit. Bits 1 to 71 are Hamming positions. Check bits sit at positions 1, 2, 4, 8, 16, 32 and 64, and check bit k makes the XOR of all positions whose index has bit k set equal to zero. Data bit i occupies the i-th non-power-of-two position counted upward from position 3. Bit 0 gives the whole 72-bit word even parity.
- R2: A read of an undamaged codeword returns the encoded data with `rd_corr_o` and `rd_uncorr_o` both low.
- R3: A read whose codeword has exactly one flipped bit among bits 1 to 71 returns the original data with `rd_corr_o` high and `rd_uncorr_o` low.
- R4: A read whose codeword has exactly two flipped bits raises `rd_uncorr_o` and keeps `rd_corr_o` low.
- R5: A read whose only flipped bit is the overall parity bit (bit 0) returns the original data and raises `rd_corr_o`.
- R6: `rd_valid_o` equals `rd_valid_i` delayed by exactly one clock. Data and both flags appear in that same cycle. Both flags are low whenever `rd_valid_o` is low.
- R7: `scrub_req_o` is high for one cycle, aligned with `rd_valid_o`, exactly when that read raised `rd_corr_o` and `scrub_en_i` was high with the read. It then carries the read's address on `scrub_addr_o` and, on `scrub_code_o`, the R1 encoding of the corrected data.
- R8: Every result with `rd_corr_o` high adds one to `corr_cnt_o`, and every result with `rd_uncorr_o` high adds one to `uncorr_cnt_o`. Each update is visible in the same cycle as that result.
- R9: Each counter stops at its all-ones value (255 for an 8-bit counter) and stays there.
- R10: `cnt_clr_i` high at a clock edge sets both counters to zero at that edge, even if an event arrives in the same cycle.
- R11: After reset, `rd_valid_o`, both flags, `scrub_req_o` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 64 | Data word to encode |
| wr_code_o | output | 72 | Codeword to store for `wr_data_i` |
| rd_valid_i | input | 1 | A stored codeword is presented for decoding |
| rd_addr_i | input | ADDR_W | Address the codeword was read from |
| rd_code_i | input | 72 | Codeword as read from memory |
| scrub_en_i | input | 1 | Allow a write-back request for this read |
| rd_valid_o | output | 1 | Decoded result valid |
| rd_data_o | output | 64 | Decoded, corrected data |
| rd_corr_o | output | 1 | Result needed a one-bit repair |
| rd_uncorr_o | output | 1 | Result has an unrepairable two-bit error |
| scrub_req_o | output | 1 | Write-back request pulse |
| scrub_addr_o | output | ADDR_W | Write-back address |
| scrub_code_o | output | 72 | Clean codeword to write back |
| cnt_clr_i | input | 1 | Clear both event counters |
| corr_cnt_o | output | CNT_W | Saturating count of repaired reads |
| uncorr_cnt_o | output | CNT_W | Saturating count of unrepairable reads |

## Verification
A wrong check-bit placement or syndrome would show up on the very next result. It would either mis-flag a clean word or flip a wrong data bit, and the bench would see that as a data mismatch in the cycle after the read. That is why every one of the 72 single-bit positions is injected on its own. A fault in the result register would show as a misaligned `rd_valid_o` or as a scrub request carrying a stale address. A counter fault shows on the counter outputs in the same cycle as the event, because the expected counts are compared after every clock, including across saturation and a clear that coincides with an event.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DW  = 64;          // protected data width
    localparam int PW  = 7;           // Hamming check bits
    localparam int HW  = DW + PW;     // highest Hamming position
    localparam int CWW = HW + 1;      // stored width incl. overall parity

    typedef logic [DW-1:0]  data_t;
    typedef logic [CWW-1:0] code_t;
    typedef logic [PW-1:0]  syn_t;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_cls_e;

    function automatic logic is_check_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // data bits fill the non-power-of-two positions in ascending order
    function automatic code_t scatter(input data_t d);
        code_t c;
        int    j;
        c = '0;
        j = 0;
        for (int p = 1; p <= HW; p++) begin
            if (!is_check_pos(p)) begin
                c[p] = d[j];
                j++;
            end
        end
        return c;
    endfunction

    function automatic data_t gather(input code_t c);
        data_t d;
        int    j;
        d = '0;
        j = 0;
        for (int p = 1; p <= HW; p++) begin
            if (!is_check_pos(p)) begin
                d[j] = c[p];
                j++;
            end
        end
        return d;
    endfunction

    // XOR of positions grouped by index bit
    function automatic syn_t syndrome(input code_t c);
        syn_t s;
        s = '0;
        for (int p = 1; p <= HW; p++) begin
            for (int k = 0; k < PW; k++) begin
                if (((p >> k) & 1) != 0) s[k] = s[k] ^ c[p];
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);

    code_t placed;
    syn_t  chk;
    code_t with_chk;

    always_comb begin
        placed   = scatter(data_i);
        chk      = syndrome(placed);
        with_chk = placed;
        for (int k = 0; k < PW; k++) begin
            with_chk[1 << k] = chk[k];
        end
        with_chk[0] = ^with_chk[HW:1];
        code_o      = with_chk;
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  code_t    code_i,
    output data_t    data_o,
    output ecc_cls_e cls_o
);

    syn_t  syn;
    logic  par_bad;
    logic  hit;
    code_t fixed;

    always_comb begin
        syn     = syndrome(code_i);
        par_bad = ^code_i;
        fixed   = code_i;
        hit     = 1'b0;
        cls_o   = ECC_CLEAN;
        if (syn == '0) begin
            if (par_bad) begin
                fixed[0] = ~code_i[0];
                cls_o    = ECC_FIXED;
            end
        end else if (par_bad) begin
            for (int p = 1; p <= HW; p++) begin
                if (int'(syn) == p) begin
                    fixed[p] = ~code_i[p];
                    hit      = 1'b1;
                end
            end
            cls_o = hit ? ECC_FIXED : ECC_FATAL;
        end else begin
            cls_o = ECC_FATAL;
        end
        data_o = gather(fixed);
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/secded_scrub_unit.sv
module secded_scrub_unit
    import secded_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wr_data_i,
    output logic [CWW-1:0]    wr_code_o,
    input  logic              rd_valid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [CWW-1:0]    rd_code_i,
    input  logic              scrub_en_i,
    output logic              rd_valid_o,
    output logic [DW-1:0]     rd_data_o,
    output logic              rd_corr_o,
    output logic              rd_uncorr_o,
    output logic              scrub_req_o,
    output logic [ADDR_W-1:0] scrub_addr_o,
    output logic [CWW-1:0]    scrub_code_o,
    input  logic              cnt_clr_i,
    output logic [CNT_W-1:0]  corr_cnt_o,
    output logic [CNT_W-1:0]  uncorr_cnt_o
);

    localparam int N_EVT = 2;   // index 0: repaired, 1: unrepairable

    typedef struct packed {
        logic              vld;
        logic [DW-1:0]     data;
        logic              corr;
        logic              uncorr;
        logic              scrub;
        logic [ADDR_W-1:0] addr;
    } rd_state_t;

    rd_state_t st_d, st_q;
    data_t     dec_data;
    ecc_cls_e  dec_cls;
    logic [N_EVT-1:0]            evt;
    logic [N_EVT-1:0][CNT_W-1:0] cnt;

    secded_enc u_wr_enc (
        .data_i (wr_data_i),
        .code_o (wr_code_o)
    );

    secded_dec u_dec (
        .code_i (rd_code_i),
        .data_o (dec_data),
        .cls_o  (dec_cls)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = rd_valid_i;
        st_d.corr   = rd_valid_i && (dec_cls == ECC_FIXED);
        st_d.uncorr = rd_valid_i && (dec_cls == ECC_FATAL);
        st_d.scrub  = rd_valid_i && (dec_cls == ECC_FIXED) && scrub_en_i;
        if (rd_valid_i) begin
            st_d.data = dec_data;
            st_d.addr = rd_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // clean codeword for the write-back, built from the registered data
    secded_enc u_scrub_enc (
        .data_i (st_q.data),
        .code_o (scrub_code_o)
    );

    assign evt = {st_d.uncorr, st_d.corr};

    for (genvar gi = 0; gi < N_EVT; gi++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (cnt_clr_i),
            .inc_i   (evt[gi]),
            .count_o (cnt[gi])
        );
    end

    assign rd_valid_o   = st_q.vld;
    assign rd_data_o    = st_q.data;
    assign rd_corr_o    = st_q.corr;
    assign rd_uncorr_o  = st_q.uncorr;
    assign scrub_req_o  = st_q.scrub;
    assign scrub_addr_o = st_q.addr;
    assign corr_cnt_o   = cnt[0];
    assign uncorr_cnt_o = cnt[1];

endmodule

// File: rtl/secded_scrub_checker.sv
module secded_scrub_checker
    import secded_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DW-1:0]     wr_data_i,
    input logic [CWW-1:0]    wr_code_o,
    input logic              rd_valid_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [CWW-1:0]    rd_code_i,
    input logic              scrub_en_i,
    input logic              rd_valid_o,
    input logic [DW-1:0]     rd_data_o,
    input logic              rd_corr_o,
    input logic              rd_uncorr_o,
    input logic              scrub_req_o,
    input logic [ADDR_W-1:0] scrub_addr_o,
    input logic [CWW-1:0]    scrub_code_o,
    input logic              cnt_clr_i,
    input logic [CNT_W-1:0]  corr_cnt_o,
    input logic [CNT_W-1:0]  uncorr_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    p_wr_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (^wr_code_o) == 1'b0);

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corr_o && rd_uncorr_o));

    p_flags_need_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_corr_o || rd_uncorr_o) |-> rd_valid_o);

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i |=> rd_valid_o);

    p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_i |=> !rd_valid_o);

    p_scrub_only_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req_o |-> (rd_corr_o && rd_valid_o));

    p_scrub_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req_o |-> (scrub_addr_o == $past(rd_addr_i)));

    p_scrub_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !scrub_en_i |=> !scrub_req_o);

    p_corr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_i |=> (corr_cnt_o == $past(corr_cnt_o)
                        || corr_cnt_o == $past(corr_cnt_o) + 1'b1));

    p_uncorr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_i |=> (uncorr_cnt_o == $past(uncorr_cnt_o)
                        || uncorr_cnt_o == $past(uncorr_cnt_o) + 1'b1));

    p_corr_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr_i && corr_cnt_o == CNT_TOP) |=> corr_cnt_o == CNT_TOP);

    p_uncorr_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr_i && uncorr_cnt_o == CNT_TOP) |=> uncorr_cnt_o == CNT_TOP);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> (corr_cnt_o == '0 && uncorr_cnt_o == '0));

endmodule

bind secded_scrub_unit secded_scrub_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) i_chk (.*);

// File: tb/test_secded_scrub_unit.sv
module test_secded_scrub_unit;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   wr_data_i = '0;
    logic [71:0]   wr_code_o;
    logic          rd_valid_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [71:0]   rd_code_i = '0;
    logic          scrub_en_i = 1'b0;
    logic          rd_valid_o;
    logic [63:0]   rd_data_o;
    logic          rd_corr_o;
    logic          rd_uncorr_o;
    logic          scrub_req_o;
    logic [AW-1:0] scrub_addr_o;
    logic [71:0]   scrub_code_o;
    logic          cnt_clr_i = 1'b0;
    logic [CW-1:0] corr_cnt_o;
    logic [CW-1:0] uncorr_cnt_o;

    always #4 clk = ~clk;

    secded_scrub_unit #(.ADDR_W(AW), .CNT_W(CW)) i_secded_scrub_unit (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    typedef struct {
        logic [63:0]   data;
        bit            chk_data;
        bit            corr;
        bit            uncorr;
        bit            scrub;
        logic [AW-1:0] addr;
    } exp_t;

    exp_t exp_q[$];
    logic [CW-1:0] m_corr = '0;
    logic [CW-1:0] m_unc  = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // bench-side code model written from R1
    function automatic logic [71:0] m_encode(input logic [63:0] d);
        logic [71:0] w;
        int          idx;
        w   = '0;
        idx = 0;
        for (int p = 3; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[idx];
                idx++;
            end
        end
        for (int k = 0; k < 7; k++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 3; p < 72; p++) begin
                if (p[k]) acc ^= w[p];
            end
            w[1 << k] = acc;
        end
        w[0] = ^w[71:1];
        return w;
    endfunction

    // kind: 0 clean, 1 repairable, 2 unrepairable
    task automatic rd(input logic [71:0] code, input logic [AW-1:0] addr,
                      input bit en, input logic [63:0] d, input int kind,
                      input bit clr);
        exp_t e;
        @(negedge clk);
        rd_valid_i = 1'b1;
        rd_code_i  = code;
        rd_addr_i  = addr;
        scrub_en_i = en;
        cnt_clr_i  = clr;
        e.data     = d;
        e.chk_data = (kind != 2);
        e.corr     = (kind == 1);
        e.uncorr   = (kind == 2);
        e.scrub    = (kind == 1) && en;
        e.addr     = addr;
        exp_q.push_back(e);
        if (clr) begin
            m_corr = '0;
            m_unc  = '0;
        end else begin
            if (kind == 1 && m_corr != CMAX) m_corr++;
            if (kind == 2 && m_unc != CMAX) m_unc++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_valid_i = 1'b0;
            cnt_clr_i  = 1'b0;
            scrub_en_i = 1'b0;
        end
    endtask

    // monitor: samples shortly after each active edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (rd_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected result", 72'(rd_valid_o), 72'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.chk_data)
                        check(rd_data_o == e.data, "R2 R3 R5", "data",
                              72'(rd_data_o), 72'(e.data));
                    check(rd_corr_o == e.corr, "R3 R5", "corr flag",
                          72'(rd_corr_o), 72'(e.corr));
                    check(rd_uncorr_o == e.uncorr, "R4", "uncorr flag",
                          72'(rd_uncorr_o), 72'(e.uncorr));
                    check(scrub_req_o == e.scrub, "R7", "scrub request",
                          72'(scrub_req_o), 72'(e.scrub));
                    if (e.scrub) begin
                        check(scrub_addr_o == e.addr, "R7", "scrub addr",
                              72'(scrub_addr_o), 72'(e.addr));
                        check(scrub_code_o == m_encode(e.data), "R7", "scrub code",
                              scrub_code_o, m_encode(e.data));
                    end
                end
            end else begin
                check(!rd_corr_o && !rd_uncorr_o && !scrub_req_o, "R6",
                      "flags while idle",
                      72'({rd_corr_o, rd_uncorr_o, scrub_req_o}), 72'h0);
            end
            check(corr_cnt_o == m_corr, "R8 R9 R10", "corr count",
                  72'(corr_cnt_o), 72'(m_corr));
            check(uncorr_cnt_o == m_unc, "R8 R9 R10", "uncorr count",
                  72'(uncorr_cnt_o), 72'(m_unc));
        end
    end

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [63:0] pats[5];
        logic [63:0] dd;
        logic [71:0] c;
        int pa[5];
        int pb[5];
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'hAAAA_5555_AAAA_5555;
        pats[3] = 64'h8000_0000_0000_0001;
        pats[4] = 64'h0123_4567_89AB_CDEF;

        repeat (4) @(negedge clk);
        // R11: reset state
        check({rd_valid_o, rd_corr_o, rd_uncorr_o, scrub_req_o} == 4'b0, "R11",
              "outputs in reset", 72'({rd_valid_o, rd_corr_o, rd_uncorr_o, scrub_req_o}), 72'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(corr_cnt_o == '0 && uncorr_cnt_o == '0 && !rd_valid_o, "R11",
              "after reset", 72'({corr_cnt_o, uncorr_cnt_o}), 72'h0);

        // R1: encoder layout and parity
        for (int i = 0; i < 5; i++) begin
            wr_data_i = pats[i];
            #1;
            check(wr_code_o == m_encode(pats[i]), "R1", "code layout",
                  wr_code_o, m_encode(pats[i]));
            check((^wr_code_o) == 1'b0, "R1", "even parity",
                  72'(^wr_code_o), 72'h0);
        end
        for (int b = 0; b < 64; b += 9) begin
            wr_data_i = 64'h1 << b;
            #1;
            check(wr_code_o == m_encode(64'h1 << b), "R1", "walking one",
                  wr_code_o, m_encode(64'h1 << b));
        end

        // R2: clean reads, back to back
        for (int i = 0; i < 5; i++)
            rd(m_encode(pats[i]), AW'(i), 1'b1, pats[i], 0, 1'b0);
        idle(2);

        // R3 / R5: every single-bit position, scrub enabled
        dd = 64'hA5C3_0F96_1234_8ED7;
        for (int p = 0; p < 72; p++) begin
            c = m_encode(dd);
            c[p] = ~c[p];
            rd(c, AW'(16'h100 + p), 1'b1, dd, 1, 1'b0);
        end
        idle(2);

        // R7: repair without scrub permission
        c = m_encode(pats[4]);
        c[37] = ~c[37];
        rd(c, AW'(16'h0BAD), 1'b0, pats[4], 1, 1'b0);
        idle(1);

        // R4: double-bit errors
        pa[0] = 1;  pb[0] = 2;
        pa[1] = 0;  pb[1] = 40;
        pa[2] = 70; pb[2] = 71;
        pa[3] = 3;  pb[3] = 64;
        pa[4] = 10; pb[4] = 33;
        for (int i = 0; i < 5; i++) begin
            c = m_encode(pats[i]);
            c[pa[i]] = ~c[pa[i]];
            c[pb[i]] = ~c[pb[i]];
            rd(c, AW'(16'h200 + i), 1'b1, pats[i], 2, 1'b0);
        end
        idle(2);

        // R9: drive the unrepairable counter into saturation
        for (int i = 0; i < 270; i++) begin
            c = m_encode(pats[2]);
            c[5]  = ~c[5];
            c[60] = ~c[60];
            rd(c, AW'(i), 1'b1, pats[2], 2, 1'b0);
        end
        idle(2);

        // R10: clear together with a repairable read
        c = m_encode(pats[3]);
        c[9] = ~c[9];
        rd(c, AW'(16'h300), 1'b1, pats[3], 1, 1'b1);
        idle(1);
        rd(c, AW'(16'h301), 1'b1, pats[3], 1, 1'b0);
        idle(3);

        check(exp_q.size() == 0, "R6", "results outstanding",
              72'(exp_q.size()), 72'h0);
        summary();
    end

endmodule